// File: doc/BRIEF.md
# Multiprocessor Interrupt Mask and Router

This block is the interrupt controller of a small shared-memory multiprocessor. A master section watches a fixed set of level-sensitive device lines, applies an inverted mask (a written 1 on one register disables a source, a written 1 on another enables it) and steers every enabled device source to a single CPU chosen by a software-written target register. A global mask-all bit silences every CPU output at once.

Each CPU has its own 32-bit pending word. The low half holds hard levels and the high half holds soft levels, and software raises or drops them through write-only set and clear registers. For every CPU the block presents a 4-bit code: the highest level that is pending and allowed through. Code 0 means nothing is pending. A synchronous register port gives software access to all of this state. Read data appears one cycle after the read strobe.

Top module: `mpirq_router`

Address map (`ADDR_W` = CPU index width + 3). When the top address bit is 0, the master registers are selected by the three low bits:
- 0: master pending (read-only)
- 1: mask (read-only)
- 2: mask-set (write-only)
- 3: mask-clear (write-only)
- 4: target (read/write)

When the top address bit is 1, the next bits hold the CPU index and the two low bits select one register of that CPU:
- 0: pending (read)
- 1: clear (write-only)
- 2: set (write-only)

## Requirements
- R1: After reset the mask reads 0xFFFFFFFF (mask-all included), the target reads 0, every CPU pending word reads 0 and every CPU level output is 0.
- R2: A write to a CPU set register ORs the data into that CPU's pending word, and a write to its clear register removes the data's 1 bits. Bits written as 0 change nothing.
- R3: Writing 1s to mask-set sets those mask bits, which disables those sources. Writing 1s to mask-clear clears them, which enables them. Bits written as 0 change nothing.
- R4: While mask bit 31 (mask-all) is set, every CPU level output is 0, whatever is pending.
- R5: In a CPU pending word, hard level n is bit n and soft level n is bit 16+n. Hard and soft bits of the same level count as one level.
- R6: A CPU level output is the highest level from 1 to 15 that is pending and unmasked, or 0 if there is none. Level 0 never produces an output.
- R7: The master pending register mirrors the device lines at the source positions (bits 7 to 13, 19, 28, 29 and 30) without latching. All other bits read 0.
- R8: Device bit 7+x (x = 0..6) raises level x+1. Bit 19 (system timer) raises level 10. Bits 28 (ECC error), 29 (write-buffer error) and 30 (module error) raise level 15.
- R9: The target register is read/write and has the CPU index width. Enabled device levels reach only the CPU it names.
- R10: Read data is valid in the cycle after a read strobe. Write-only addresses read as 0. When no read was strobed, the read data is 0.
- R11: A CPU pending-register read shows its software word ORed with the device hard levels currently routed to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_irq | input | 32 | Level-sensitive device interrupt lines, by master bit position |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| cpu_level | output | 4*NCPU | Highest pending level per CPU, CPU c in bits 4c+3:4c |

## Verification
The bench builds the block with its default of four CPUs. The 2-bit target then has four values, so steering can be shown reaching one CPU while the other three stay quiet, and steering can be moved between CPUs. With four pending words, set/clear decoding to one CPU can be checked against its neighbours. The full 16-level width lets the bench check level 0, the top level 15, and a soft bit outranking a hard bit.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  localparam int WORD_W = 32;
  localparam int LVL_N  = 16;
  localparam int LVL_W  = 4;
  localparam int MASK_ALL_BIT = 31;

  // master register offsets (low three address bits)
  localparam logic [2:0] OFS_MPEND = 3'd0;
  localparam logic [2:0] OFS_MASK  = 3'd1;
  localparam logic [2:0] OFS_MSET  = 3'd2;
  localparam logic [2:0] OFS_MCLR  = 3'd3;
  localparam logic [2:0] OFS_TGT   = 3'd4;

  // per-cpu register offsets (low two address bits)
  localparam logic [1:0] CREG_PEND = 2'd0;
  localparam logic [1:0] CREG_CLR  = 2'd1;
  localparam logic [1:0] CREG_SET  = 2'd2;

  // level raised by a master source bit, 0 when the bit is not a source
  function automatic logic [LVL_W-1:0] src_to_level(input int b);
    if (b >= 7 && b <= 13) return LVL_W'(b - 6);
    if (b == 19) return LVL_W'(10);
    if (b >= 28 && b <= 30) return LVL_W'(15);
    return '0;
  endfunction

  function automatic logic [WORD_W-1:0] src_valid_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int b = 0; b < WORD_W; b++) m[b] = (src_to_level(b) != '0);
    return m;
  endfunction

  // highest set level among 1..15
  function automatic logic [LVL_W-1:0] top_level(input logic [LVL_N-1:0] v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 1; i < LVL_N; i++) if (v[i]) r = LVL_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/irq_master.sv
module irq_master
  import irq_rt_pkg::*;
#(
  parameter int CPU_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] dev_irq,
  input  logic              mset_we,
  input  logic              mclr_we,
  input  logic              tgt_we,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] mask_q,
  output logic [WORD_W-1:0] mpend,
  output logic [CPU_W-1:0]  target_q,
  output logic [LVL_N-1:0]  route_lvls,
  output logic              mask_all
);
  localparam logic [WORD_W-1:0] VALID = src_valid_mask();

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '1;
      target_q <= '0;
    end else begin
      if (mset_we) mask_q <= mask_q | wr_data;
      else if (mclr_we) mask_q <= mask_q & ~wr_data;
      if (tgt_we) target_q <= wr_data[CPU_W-1:0];
    end
  end

  assign mpend    = dev_irq & VALID;
  assign mask_all = mask_q[MASK_ALL_BIT];

  always_comb begin
    route_lvls = '0;
    for (int b = 0; b < WORD_W; b++)
      if (mpend[b] && !mask_q[b]) route_lvls[src_to_level(b)] = 1'b1;
  end
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice
  import irq_rt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [LVL_N-1:0]  routed,
  input  logic              mask_all,
  output logic [WORD_W-1:0] sw_word,
  output logic [WORD_W-1:0] pend_view,
  output logic [LVL_N-1:0]  eff_lvls,
  output logic [LVL_W-1:0]  level
);
  always_ff @(posedge clk) begin
    if (!rst_n) sw_word <= '0;
    else if (set_we) sw_word <= sw_word | wr_data;
    else if (clr_we) sw_word <= sw_word & ~wr_data;
  end

  assign pend_view = sw_word | {{(WORD_W-LVL_N){1'b0}}, routed};
  assign eff_lvls  = mask_all ? '0
                   : (sw_word[LVL_N-1:0] | sw_word[WORD_W-1:LVL_N] | routed);
  assign level     = top_level(eff_lvls);
endmodule

// File: rtl/mpirq_router.sv
module mpirq_router
  import irq_rt_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1,
  parameter int ADDR_W = CPU_W + 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WORD_W-1:0]     dev_irq,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [WORD_W-1:0]     wr_data,
  output logic [WORD_W-1:0]     rd_data,
  output logic [NCPU*LVL_W-1:0] cpu_level
);
  logic              is_cpu;
  logic [CPU_W-1:0]  cpu_sel;
  logic [1:0]        reg_sel;
  logic [2:0]        m_ofs;

  assign is_cpu  = addr[ADDR_W-1];
  assign cpu_sel = addr[ADDR_W-2:2];
  assign reg_sel = addr[1:0];
  assign m_ofs   = addr[2:0];

  logic mset_we, mclr_we, tgt_we;
  assign mset_we = wr_en && !is_cpu && (m_ofs == OFS_MSET);
  assign mclr_we = wr_en && !is_cpu && (m_ofs == OFS_MCLR);
  assign tgt_we  = wr_en && !is_cpu && (m_ofs == OFS_TGT);

  logic [WORD_W-1:0] mask_q, mpend;
  logic [CPU_W-1:0]  target_q;
  logic [LVL_N-1:0]  route_lvls;
  logic              mask_all;

  irq_master #(.CPU_W(CPU_W)) u_master (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq),
    .mset_we(mset_we), .mclr_we(mclr_we), .tgt_we(tgt_we),
    .wr_data(wr_data), .mask_q(mask_q), .mpend(mpend),
    .target_q(target_q), .route_lvls(route_lvls), .mask_all(mask_all)
  );

  logic [WORD_W-1:0]      pend_view [NCPU];
  logic [NCPU*WORD_W-1:0] cpu_sw_flat;
  logic [NCPU*LVL_N-1:0]  cpu_route_flat;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic             hit, set_we, clr_we;
    logic [LVL_N-1:0] routed, eff;
    logic [WORD_W-1:0] sw;
    assign hit    = wr_en && is_cpu && (cpu_sel == CPU_W'(c));
    assign set_we = hit && (reg_sel == CREG_SET);
    assign clr_we = hit && (reg_sel == CREG_CLR);
    assign routed = (target_q == CPU_W'(c)) ? route_lvls : '0;

    irq_cpu_slice u_slice (
      .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
      .wr_data(wr_data), .routed(routed), .mask_all(mask_all),
      .sw_word(sw), .pend_view(pend_view[c]), .eff_lvls(eff),
      .level(cpu_level[c*LVL_W +: LVL_W])
    );

    assign cpu_sw_flat[c*WORD_W +: WORD_W]   = sw;
    assign cpu_route_flat[c*LVL_N +: LVL_N]  = routed;
  end

  logic [WORD_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (!is_cpu) begin
      case (m_ofs)
        OFS_MPEND: rd_mux = mpend;
        OFS_MASK:  rd_mux = mask_q;
        OFS_TGT:   rd_mux = {{(WORD_W-CPU_W){1'b0}}, target_q};
        default:   rd_mux = '0;
      endcase
    end else begin
      for (int c = 0; c < NCPU; c++)
        if (cpu_sel == CPU_W'(c) && reg_sel == CREG_PEND) rd_mux = pend_view[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
    else rd_data <= '0;
  end
endmodule

// File: rtl/mpirq_router_sva.sv
module mpirq_router_sva
  import irq_rt_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int CPU_W  = 2,
  parameter int ADDR_W = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [WORD_W-1:0]     wr_data,
  input logic [WORD_W-1:0]     rd_data,
  input logic [NCPU*LVL_W-1:0] cpu_level,
  input logic [WORD_W-1:0]     mask_q,
  input logic [CPU_W-1:0]      target_q,
  input logic [NCPU*WORD_W-1:0] cpu_sw_flat,
  input logic [NCPU*LVL_N-1:0] cpu_route_flat
);
  localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(OFS_MSET);
  localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(OFS_MCLR);
  localparam logic [ADDR_W-1:0] A_TGT  = ADDR_W'(OFS_TGT);

  p_maskall_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[MASK_ALL_BIT] |-> (cpu_level == '0));

  p_rd_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == '0));

  p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MSET) |=> ((mask_q & $past(wr_data)) == $past(wr_data)));

  p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MCLR) |=> ((mask_q & $past(wr_data)) == '0));

  p_target_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_TGT) |=> $stable(target_q));

  for (genvar c = 0; c < NCPU; c++) begin : g_chk
    localparam logic [ADDR_W-1:0] A_SET = {1'b1, CPU_W'(c), CREG_SET};
    localparam logic [ADDR_W-1:0] A_CLR = {1'b1, CPU_W'(c), CREG_CLR};

    p_cpu_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_SET) |=>
        ((cpu_sw_flat[c*WORD_W +: WORD_W] & $past(wr_data)) == $past(wr_data)));

    p_cpu_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CLR) |=>
        ((cpu_sw_flat[c*WORD_W +: WORD_W] & $past(wr_data)) == '0));

    p_route_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (target_q != CPU_W'(c)) |-> (cpu_route_flat[c*LVL_N +: LVL_N] == '0));
  end
endmodule

bind mpirq_router mpirq_router_sva #(.NCPU(NCPU), .CPU_W(CPU_W), .ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data), .cpu_level(cpu_level),
  .mask_q(mask_q), .target_q(target_q),
  .cpu_sw_flat(cpu_sw_flat), .cpu_route_flat(cpu_route_flat)
);

// File: tb/mpirq_router_tb.sv
module mpirq_router_tb;
  localparam int NCPU = 4;
  localparam int CW = 2;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   dev_irq = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [NCPU*4-1:0] cpu_level;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mpirq_router #(.NCPU(NCPU)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .cpu_level(cpu_level)
  );

  localparam logic [AW-1:0] M_PEND = 5'd0, M_MASK = 5'd1, M_SET = 5'd2,
                            M_CLR = 5'd3, M_TGT = 5'd4;
  function automatic logic [AW-1:0] c_addr(input int c, input int r);
    return {1'b1, CW'(c), 2'(r)};
  endfunction
  localparam int R_PEND = 0, R_CLR = 1, R_SET = 2;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [3:0] lvl(input int c);
    return cpu_level[c*4 +: 4];
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(M_MASK, d);  check("R1 mask", d, 32'hFFFF_FFFF);
    rd(M_TGT, d);   check("R1 target", d, 0);
    for (int c = 0; c < NCPU; c++) begin
      rd(c_addr(c, R_PEND), d); check("R1 cpu pending", d, 0);
    end
    check("R1 levels", 32'(cpu_level), 0);
  endtask

  task automatic t_maskall;
    wr(c_addr(1, R_SET), 32'h0020_0000);           // soft level 5
    @(negedge clk); check("R4 blocked by mask-all", 32'(lvl(1)), 0);
    wr(M_CLR, 32'h8000_0000);
    @(negedge clk); check("R4 released", 32'(lvl(1)), 5);
    wr(M_SET, 32'h8000_0000);
    @(negedge clk); check("R4 re-blocked", 32'(lvl(1)), 0);
    wr(M_CLR, 32'h8000_0000);
    wr(c_addr(1, R_CLR), 32'hFFFF_FFFF);
  endtask

  task automatic t_setclr;
    logic [31:0] d;
    wr(c_addr(3, R_SET), 32'h0000_0020);
    wr(c_addr(3, R_SET), 32'h0);
    rd(c_addr(3, R_PEND), d); check("R2 set zero no effect", d, 32'h20);
    wr(c_addr(3, R_CLR), 32'h0);
    rd(c_addr(3, R_PEND), d); check("R2 clear zero no effect", d, 32'h20);
    rd(c_addr(2, R_PEND), d); check("R2 neighbour untouched", d, 0);
    wr(c_addr(3, R_CLR), 32'h20);
    rd(c_addr(3, R_PEND), d); check("R2 clear", d, 0);
  endtask

  task automatic t_hardsoft;
    wr(c_addr(2, R_SET), 32'h0200_0008);           // soft 9, hard 3
    @(negedge clk); check("R5 soft 9 over hard 3", 32'(lvl(2)), 9);
    wr(c_addr(2, R_CLR), 32'h0200_0000);
    @(negedge clk); check("R5 hard 3", 32'(lvl(2)), 3);
    wr(c_addr(2, R_SET), 32'h0008_0000);           // soft 3
    wr(c_addr(2, R_CLR), 32'h0000_0008);
    @(negedge clk); check("R5 soft 3 alone", 32'(lvl(2)), 3);
    wr(c_addr(2, R_CLR), 32'hFFFF_FFFF);
  endtask

  task automatic t_levels;
    wr(c_addr(0, R_SET), 32'h0001_0001);
    @(negedge clk); check("R6 level zero silent", 32'(lvl(0)), 0);
    wr(c_addr(0, R_SET), 32'h0000_8010);
    @(negedge clk); check("R6 top level 15", 32'(lvl(0)), 15);
    wr(c_addr(0, R_CLR), 32'hFFFF_FFFF);
    @(negedge clk); check("R6 none", 32'(lvl(0)), 0);
  endtask

  task automatic t_master;
    logic [31:0] d;
    dev_irq = 32'hFFFF_FFFF;
    rd(M_PEND, d); check("R7 source positions", d, 32'h7008_3F80);
    dev_irq = 32'h0;
    rd(M_PEND, d); check("R7 not latched", d, 0);
    wr(M_CLR, 32'h7FFF_FFFF);
    dev_irq = 32'h0008_0000;
    @(negedge clk); check("R8 timer level 10 cpu0", 32'(lvl(0)), 10);
    check("R9 cpu1 quiet", 32'(lvl(1)), 0);
    dev_irq = 32'h0000_0200;
    @(negedge clk); check("R8 expansion bit 9 level 3", 32'(lvl(0)), 3);
    dev_irq = 32'h2000_0000;
    @(negedge clk); check("R8 error level 15", 32'(lvl(0)), 15);
    dev_irq = 32'h0008_0000;
    wr(M_TGT, 32'h2);
    rd(M_TGT, d); check("R9 target readback", d, 2);
    check("R9 cpu2 gets timer", 32'(lvl(2)), 10);
    check("R9 cpu0 released", 32'(lvl(0)), 0);
    wr(M_SET, 32'h0008_0000);
    @(negedge clk); check("R3 masked source", 32'(lvl(2)), 0);
    dev_irq = 32'h0000_0100;
    rd(c_addr(2, R_PEND), d); check("R11 routed hard level 2", d, 32'h4);
    rd(c_addr(3, R_PEND), d); check("R11 other cpu clear", d, 0);
    dev_irq = 32'h0;
    @(negedge clk); check("R7 drop removes level", 32'(lvl(2)), 0);
  endtask

  task automatic t_readport;
    logic [31:0] d;
    rd(M_SET, d); check("R10 write-only reads 0", d, 0);
    rd(c_addr(1, R_SET), d); check("R10 cpu set reads 0", d, 0);
    rd(M_MASK, d); check("R3 mask value", d, 32'h0008_0000);
    @(negedge clk); check("R10 idle zero", rd_data, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_maskall;
    t_setclr;
    t_hardsoft;
    t_levels;
    t_master;
    t_readport;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule